// File: doc/BRIEF.md
# Snooping Data Cache Tag and State Controller

This block controls a 4 KB physically addressed data cache. The cache has four ways and 16-byte lines, which gives 64 sets. The processor side issues one read or write at a time. Each access carries a page policy bit that selects copyback or write-through. Misses are served over a memory port:

- A line is filled as a burst of four 32-bit beats.
- A dirty victim is first written back with a burst of the same length.
- A write-through store is sent as one single-beat write.

A write miss to a write-through page goes straight to memory and leaves the cache unchanged.

A second requester, the snoop port, presents cycles that other bus masters run on the shared bus. Each snoop is marked as a read or a write and as coherent or not. Snoops that are not coherent are acknowledged and have no other effect. The two sides contend for the tag lookup, and a snoop always wins over the processor.

- A coherent snooped read that hits a dirty line supplies that line's four words on a side channel and raises an inhibit flag, so that memory does not answer. The line then becomes clean.
- A coherent snooped write drops a clean line at once. It drops a dirty line only after writing the line back.

Victims are chosen by a round-robin pointer kept for each set. The data storage is a behavioural array.

Top module: `snoop_dcache`

## Requirements
- R1: A byte address splits into tag [31:10], set [9:4], word [3:2] and byte [1:0]. There are 64 sets of four ways, and no set holds two valid ways with the same tag.
- R2: A read miss fetches its line as four memory beats at byte offsets 0, 4, 8, 12 in that order. It then completes with the requested word, and later reads of that line complete with no memory beats. The memory port holds `mem_req` and `mem_addr` stable until `mem_ack`, and moves one beat per acknowledged cycle.
- R3: A write-through write that hits a clean line updates the cached word. It issues one non-burst memory write with the same word address and data, completes in the cycle of that write's acknowledge, and leaves the line clean.
- R4: A write-through write that misses issues one memory write and allocates nothing, so a later read of that line misses.
- R5: A copyback write that hits updates the cached word with no memory traffic and marks the line dirty.
- R6: A copyback write that misses fills the line first, then merges the write and marks the line dirty.
- R7: The replacement victim is the way named by the set's round-robin pointer. The pointer starts at way 0 after reset and advances after each fill. A dirty victim is written back as four beats before the four-beat fill of the new line.
- R8: A snoop with `snp_coherent` low is acknowledged in its first cycle. It raises no inhibit, supplies no data, moves no memory beats and leaves the line state unchanged.
- R9: A coherent snooped read that hits a dirty line asserts `snp_inhibit` and `snp_dv` for four cycles. Those cycles carry words 0 to 3 on `snp_data`, and the line ends clean. A coherent snooped read that hits a clean line, or misses, is acknowledged in its first cycle without inhibit.
- R10: A coherent snooped write that hits a clean line invalidates it, with no memory beats. On a dirty hit it writes the line back as four beats and then invalidates it.
- R11: When a snoop and a processor access are both pending in the same idle cycle, the snoop is acknowledged in that cycle and the processor completes only afterwards, seeing the snoop's effect.
- R12: After reset every line is invalid and `cpu_done`, `mem_req`, `snp_inhibit` and `snp_dv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access pending, held until `cpu_done` |
| cpu_we | input | 1 | Access is a write |
| cpu_cb | input | 1 | Page policy: 1 copyback, 0 write-through |
| cpu_addr | input | 30 | Word address (byte address bits 31:2) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_done` on a read |
| cpu_done | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_burst | output | 1 | Beat belongs to a four-beat line burst |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_rdata | input | 32 | Read data of the beat |
| mem_ack | input | 1 | Beat transfers at this clock edge |
| snp_req | input | 1 | Snoop pending, held until `snp_ack` |
| snp_we | input | 1 | Snooped cycle is a write |
| snp_coherent | input | 1 | Snooped cycle is marked snoopable |
| snp_addr | input | 28 | Snooped line address (byte address bits 31:4) |
| snp_ack | output | 1 | Snoop finishes at this clock edge |
| snp_inhibit | output | 1 | Cache supplies the line in place of memory |
| snp_dv | output | 1 | `snp_data` carries a supplied word |
| snp_data | output | 32 | Supplied line word |

## Verification
The key collision is a snoop and a processor access that reach the idle lookup in the same cycle. The bench raises both requests at one falling edge, targeting the same clean line: a coherent snooped write and a processor read. Right after that edge it expects `snp_ack` high and `cpu_done` low. It then expects the processor read to miss and refetch the line with four beats, which shows that the snoop's invalidation took effect first.

// File: rtl/snoop_dcache.sv
module snoop_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic                     cpu_cb,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic [DATA_W-1:0]        cpu_rdata,
  output logic                     cpu_done,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic                     mem_burst,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mem_ack,
  input  logic                     snp_req,
  input  logic                     snp_we,
  input  logic                     snp_coherent,
  input  logic [ADDR_W-$clog2(DATA_W/8)-$clog2(LINE_WORDS)-1:0] snp_addr,
  output logic                     snp_ack,
  output logic                     snp_inhibit,
  output logic                     snp_dv,
  output logic [DATA_W-1:0]        snp_data
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WRD_W  = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - BYTE_W - WRD_W - SET_W;

  typedef enum logic [1:0] {L_INV, L_VAL, L_DRT} line_t;
  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_WT, S_SOUT, S_SWB} fsm_t;

  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  line_t             lst_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS][LINE_WORDS];
  logic [WAY_W-1:0]  rr_q  [SETS];

  fsm_t             st;
  logic [WRD_W-1:0] beat;
  logic [SET_W-1:0] op_set;
  logic [WAY_W-1:0] op_way;
  logic [TAG_W-1:0] op_tag;

  wire [WRD_W-1:0] cpu_word = cpu_addr[WRD_W-1:0];
  wire [SET_W-1:0] lk_set = snp_req ? snp_addr[SET_W-1:0] : cpu_addr[WRD_W +: SET_W];
  wire [TAG_W-1:0] lk_tag = snp_req ? snp_addr[SET_W +: TAG_W] : cpu_addr[WRD_W+SET_W +: TAG_W];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = (lst_q[lk_set][w] != L_INV) && (tag_q[lk_set][w] == lk_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  wire   hit     = |hit_vec;
  line_t hit_st;
  assign hit_st  = lst_q[lk_set][hit_way];
  wire   idle    = (st == S_IDLE);
  wire   last    = &beat;
  wire   snp_go  = idle && snp_req;
  wire   cpu_go  = idle && !snp_req && cpu_req;

  assign snp_ack   = (snp_go && !(snp_coherent && hit && hit_st == L_DRT))
                   || (st == S_SOUT && last) || (st == S_SWB && mem_ack && last);
  assign cpu_done  = (cpu_go && hit && (!cpu_we || cpu_cb)) || (st == S_WT && mem_ack);
  assign cpu_rdata = dat_q[lk_set][hit_way][cpu_word];

  assign mem_req   = (st == S_WB) || (st == S_FILL) || (st == S_WT) || (st == S_SWB);
  assign mem_we    = mem_req && (st != S_FILL);
  assign mem_burst = mem_req && (st != S_WT);
  always_comb begin
    case (st)
      S_WB, S_SWB: mem_addr = {tag_q[op_set][op_way], op_set, beat, {BYTE_W{1'b0}}};
      S_FILL:      mem_addr = {op_tag, op_set, beat, {BYTE_W{1'b0}}};
      S_WT:        mem_addr = {cpu_addr, {BYTE_W{1'b0}}};
      default:     mem_addr = '0;
    endcase
  end
  assign mem_wdata   = (st == S_WT) ? cpu_wdata : dat_q[op_set][op_way][beat];
  assign snp_inhibit = (st == S_SOUT);
  assign snp_dv      = (st == S_SOUT);
  assign snp_data    = dat_q[op_set][op_way][beat];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; beat <= '0; op_set <= '0; op_way <= '0; op_tag <= '0;
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) lst_q[s][w] <= L_INV;
      end
    end else begin
      case (st)
        S_IDLE: begin
          beat <= '0;
          if (snp_go) begin
            if (snp_coherent && hit) begin
              op_set <= lk_set; op_way <= hit_way;
              if (hit_st == L_DRT) st <= snp_we ? S_SWB : S_SOUT;
              else if (snp_we) lst_q[lk_set][hit_way] <= L_INV;
            end
          end else if (cpu_go) begin
            op_set <= lk_set; op_tag <= lk_tag;
            if (hit) begin
              if (cpu_we) begin
                dat_q[lk_set][hit_way][cpu_word] <= cpu_wdata;
                if (cpu_cb) lst_q[lk_set][hit_way] <= L_DRT;
                else st <= S_WT;
              end
            end else if (cpu_we && !cpu_cb) begin
              st <= S_WT;
            end else begin
              op_way <= rr_q[lk_set];
              st <= (lst_q[lk_set][rr_q[lk_set]] == L_DRT) ? S_WB : S_FILL;
            end
          end
        end
        S_WB: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last) st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          dat_q[op_set][op_way][beat] <= mem_rdata;
          beat <= beat + 1'b1;
          if (last) begin
            tag_q[op_set][op_way] <= op_tag;
            lst_q[op_set][op_way] <= L_VAL;
            rr_q[op_set] <= rr_q[op_set] + 1'b1;
            st <= S_IDLE;
          end
        end
        S_WT: if (mem_ack) st <= S_IDLE;
        S_SOUT: begin
          beat <= beat + 1'b1;
          if (last) begin
            lst_q[op_set][op_way] <= L_VAL;
            st <= S_IDLE;
          end
        end
        S_SWB: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last) begin
            lst_q[op_set][op_way] <= L_INV;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> $onehot0(hit_vec));
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_wt_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && cpu_we && !cpu_cb |-> mem_req && mem_we && !mem_burst);
  p_supply_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snp_inhibit) |-> lst_q[op_set][op_way] == L_VAL);
  p_wb_then_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ack && st == S_SWB |=> lst_q[op_set][op_way] == L_INV);
  p_snoop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle && snp_req && cpu_req |-> !cpu_done);
endmodule

// File: tb/test_snoop_dcache.sv
module test_snoop_dcache;
  localparam logic [31:0] K = 32'h5A5A_0000;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_cb = 0;
  logic [29:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_done, mem_req, mem_we, mem_burst, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic snp_req = 0, snp_we = 0, snp_coherent = 0;
  logic [27:0] snp_addr = '0;
  logic snp_ack, snp_inhibit, snp_dv;
  logic [31:0] snp_data;

  always #4 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem_addr ^ K;

  snoop_dcache i_snoop_dcache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_cb(cpu_cb),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .snp_req(snp_req), .snp_we(snp_we), .snp_coherent(snp_coherent), .snp_addr(snp_addr),
    .snp_ack(snp_ack), .snp_inhibit(snp_inhibit), .snp_dv(snp_dv), .snp_data(snp_data));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int log_n = 0;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic        log_we   [16];
  logic        log_bst  [16];
  logic [31:0] sdat [4];

  always @(negedge clk) if (mem_req && mem_ack) begin
    if (log_n < 16) begin
      log_addr[log_n] = mem_addr; log_data[log_n] = mem_wdata;
      log_we[log_n] = mem_we; log_bst[log_n] = mem_burst;
    end
    log_n++;
  end

  function automatic logic [31:0] ba(input int tag, input int set, input int w);
    return (32'(tag) << 10) | (32'(set) << 4) | (32'(w) << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input bit cb, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    log_n = 0; cpu_we = we; cpu_cb = cb; cpu_addr = a[31:2]; cpu_wdata = wd; cpu_req = 1;
    #1;
    while (!cpu_done) @(negedge clk);
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic snp_op(input bit we, input bit coh, input logic [31:0] a,
                        output int ndv, output bit inh);
    bit fin = 0;
    ndv = 0; inh = 0;
    @(negedge clk);
    log_n = 0; snp_we = we; snp_coherent = coh; snp_addr = a[31:4]; snp_req = 1;
    #1;
    while (!fin) begin
      if (snp_dv) begin
        if (ndv < 4) sdat[ndv] = snp_data;
        ndv++;
      end
      if (snp_inhibit) inh = 1;
      if (snp_ack) fin = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    snp_req = 0;
  endtask

  task automatic t_reset;
    chk("R12 cpu_done", 32'(cpu_done), 0);
    chk("R12 mem_req", 32'(mem_req), 0);
    chk("R12 snp_inhibit", 32'(snp_inhibit), 0);
    chk("R12 snp_dv", 32'(snp_dv), 0);
  endtask

  task automatic t_read_miss;
    logic [31:0] rd;
    cpu_op(0, 1, ba(1, 3, 2), 0, rd);
    chk("R2 fill beats", 32'(log_n), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 fill addr order", log_addr[i], ba(1, 3, i));
      chk("R2 fill is read burst", {30'd0, log_we[i], log_bst[i]}, 32'd1);
    end
    chk("R2 miss data", rd, ba(1, 3, 2) ^ K);
    cpu_op(0, 1, ba(1, 3, 1), 0, rd);
    chk("R1 same line other word hits", 32'(log_n), 0);
    chk("R2 hit data", rd, ba(1, 3, 1) ^ K);
  endtask

  task automatic t_cb_hit;
    logic [31:0] rd;
    cpu_op(1, 1, ba(1, 3, 1), 32'h1111, rd);
    chk("R5 no memory traffic", 32'(log_n), 0);
    cpu_op(0, 1, ba(1, 3, 1), 0, rd);
    chk("R5 updated word", rd, 32'h1111);
  endtask

  task automatic t_wt_hit;
    logic [31:0] rd;
    cpu_op(1, 0, ba(1, 3, 0), 32'h2222, rd);
    chk("R3 single beat", 32'(log_n), 1);
    chk("R3 write addr", log_addr[0], ba(1, 3, 0));
    chk("R3 write data", log_data[0], 32'h2222);
    chk("R3 not burst, is write", {30'd0, log_we[0], log_bst[0]}, 32'd2);
    cpu_op(0, 0, ba(1, 3, 0), 0, rd);
    chk("R3 cache updated", rd, 32'h2222);
  endtask

  task automatic t_wt_miss;
    logic [31:0] rd;
    cpu_op(1, 0, ba(7, 5, 0), 32'h3333, rd);
    chk("R4 single write", 32'(log_n), 1);
    chk("R4 write data", log_data[0], 32'h3333);
    cpu_op(0, 0, ba(7, 5, 0), 0, rd);
    chk("R4 no allocate, read misses", 32'(log_n), 4);
    chk("R4 read data from memory", rd, ba(7, 5, 0) ^ K);
  endtask

  task automatic t_non_coherent;
    int ndv; bit inh; logic [31:0] rd;
    snp_op(1, 0, ba(1, 3, 0), ndv, inh);
    chk("R8 write: no data", 32'(ndv), 0);
    chk("R8 write: no inhibit", 32'(inh), 0);
    chk("R8 write: no beats", 32'(log_n), 0);
    snp_op(0, 0, ba(1, 3, 0), ndv, inh);
    chk("R8 read on dirty: no inhibit", 32'(inh), 0);
    cpu_op(0, 1, ba(1, 3, 0), 0, rd);
    chk("R8 line kept", 32'(log_n), 0);
    chk("R8 data kept", rd, 32'h2222);
  endtask

  task automatic t_snoop_read;
    int ndv; bit inh;
    snp_op(0, 1, ba(1, 3, 0), ndv, inh);
    chk("R9 inhibit", 32'(inh), 1);
    chk("R9 four words", 32'(ndv), 4);
    chk("R9 word0", sdat[0], 32'h2222);
    chk("R9 word1", sdat[1], 32'h1111);
    chk("R9 word2", sdat[2], ba(1, 3, 2) ^ K);
    chk("R9 word3", sdat[3], ba(1, 3, 3) ^ K);
    snp_op(0, 1, ba(1, 3, 0), ndv, inh);
    chk("R9 clean after supply: no inhibit", 32'(inh), 0);
    snp_op(0, 1, ba(9, 40, 0), ndv, inh);
    chk("R9 miss: no inhibit", 32'(inh), 0);
  endtask

  task automatic t_evict;
    logic [31:0] rd;
    for (int t = 2; t <= 4; t++) cpu_op(0, 1, ba(t, 3, 0), 0, rd);
    cpu_op(0, 1, ba(5, 3, 0), 0, rd);
    chk("R9/R7 clean victim: fill only", 32'(log_n), 4);
    chk("R7 fill of new tag", log_addr[0], ba(5, 3, 0));
    cpu_op(0, 1, ba(2, 3, 0), 0, rd);
    chk("R7 way1 kept", 32'(log_n), 0);
    cpu_op(0, 1, ba(1, 9, 0), 0, rd);
    cpu_op(1, 1, ba(1, 9, 2), 32'hABCD, rd);
    for (int t = 2; t <= 4; t++) cpu_op(0, 1, ba(t, 9, 0), 0, rd);
    cpu_op(0, 1, ba(5, 9, 1), 0, rd);
    chk("R7 dirty victim: 8 beats", 32'(log_n), 8);
    for (int i = 0; i < 4; i++) begin
      chk("R7 writeback first", 32'(log_we[i]), 1);
      chk("R7 writeback addr", log_addr[i], ba(1, 9, i));
      chk("R7 fill after", 32'(log_we[4+i]), 0);
    end
    chk("R7 writeback data", log_data[2], 32'hABCD);
    chk("R7 fill addr", log_addr[4], ba(5, 9, 0));
    chk("R7 data after replace", rd, ba(5, 9, 1) ^ K);
    cpu_op(0, 1, ba(1, 11, 0), 0, rd);
    cpu_op(1, 0, ba(1, 11, 0), 32'h5555, rd);
    for (int t = 2; t <= 4; t++) cpu_op(0, 1, ba(t, 11, 0), 0, rd);
    cpu_op(0, 1, ba(5, 11, 0), 0, rd);
    chk("R3 write-through hit stays clean", 32'(log_n), 4);
  endtask

  task automatic t_cb_miss_and_snoop_write;
    logic [31:0] rd; int ndv; bit inh;
    cpu_op(1, 1, ba(2, 20, 1), 32'h4444, rd);
    chk("R6 fill on copyback miss", 32'(log_n), 4);
    cpu_op(0, 1, ba(2, 20, 1), 0, rd);
    chk("R6 merged data", rd, 32'h4444);
    snp_op(1, 1, ba(2, 20, 0), ndv, inh);
    chk("R10 dirty hit writeback beats", 32'(log_n), 4);
    chk("R10 writeback addr", log_addr[0], ba(2, 20, 0));
    chk("R10 writeback data / R6 dirty", log_data[1], 32'h4444);
    chk("R10 no supply", 32'(ndv), 0);
    cpu_op(0, 1, ba(2, 20, 1), 0, rd);
    chk("R10 invalidated after writeback", 32'(log_n), 4);
    chk("R10 refetched data", rd, ba(2, 20, 1) ^ K);
    cpu_op(0, 1, ba(1, 21, 0), 0, rd);
    snp_op(1, 1, ba(1, 21, 0), ndv, inh);
    chk("R10 clean hit: no beats", 32'(log_n), 0);
    cpu_op(0, 1, ba(1, 21, 0), 0, rd);
    chk("R10 clean hit invalidated", 32'(log_n), 4);
  endtask

  task automatic t_priority;
    @(negedge clk);
    log_n = 0;
    cpu_we = 0; cpu_cb = 1; cpu_addr = ba(2, 20, 1) >> 2; cpu_req = 1;
    snp_we = 1; snp_coherent = 1; snp_addr = ba(2, 20, 0) >> 4; snp_req = 1;
    #1;
    chk("R11 snoop acked first", 32'(snp_ack), 1);
    chk("R11 cpu held", 32'(cpu_done), 0);
    @(negedge clk);
    snp_req = 0;
    #1;
    while (!cpu_done) @(negedge clk);
    chk("R11 cpu sees invalidation", 32'(log_n), 4);
    chk("R11 cpu data", cpu_rdata, ba(2, 20, 1) ^ K);
    @(negedge clk);
    cpu_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_read_miss();
    t_cb_hit();
    t_wt_hit();
    t_wt_miss();
    t_non_coherent();
    t_snoop_read();
    t_evict();
    t_cb_miss_and_snoop_write();
    t_priority();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule